// File: doc/BRIEF.md
# Packet Trace Match Filter

This block sits on the receive side of a single switch port and watches the packet words going past. It assembles a fixed 160-bit window from the first five 32-bit words of each packet and tests that window against up to four comparators. Each comparator has its own value, a care mask and an enable. From the comparison result, the block issues one routing decision per packet:

- **Forward** the packet normally.
- **Forward and copy** the packet to a programmable trace port.
- **Drop** the packet.

The comparison runs word by word while the packet streams in. The decision is therefore ready on the cycle after the fifth word arrives, or after the end marker if the packet is shorter. The decision and the trace port index are registered outputs. They hold until the next packet starts. The port enable, the action, the trace port index and every comparator setting are captured when a packet starts. A change made in the middle of a packet therefore only affects the next packet. The block does not move or duplicate packet data itself: a downstream routing stage acts on its decision.

Top module: `trace_snoop_filter`

## Requirements
- R1: The window is made of packet words 0 to 4. Word k (word 0 carries the start marker) is compared against bits [32k+31:32k] of a comparator's value and mask. Comparator c occupies bits [160c+159:160c] of `cfg_value` and `cfg_mask`.
- R2: A comparator matches when every window bit whose mask bit is 1 equals the value bit. Bits whose mask bit is 0 always match.
- R3: A hit is a match on any comparator whose bit in `cfg_cmp_en` is 1. A comparator whose enable bit is 0 never causes a hit.
- R4: On a hit, `dec_code` is 1 (forward and copy) when `cfg_drop` is 0, and 2 (drop) when `cfg_drop` is 1. The value 3 never appears.
- R5: When there is no hit, `dec_code` is 0 (forward).
- R6: When `cfg_en` is 0, `dec_code` is 0 whatever the data.
- R7: `dec_trace_port` carries the `cfg_trace_port` value that was in force for the packet.
- R8: `dec_valid` rises on the cycle after the fifth word is accepted, or after the end-marked word if that comes first. A one-word packet is decided on the cycle after that word.
- R9: In a packet shorter than five words, each missing window bit counts as a mismatch when its mask bit is 1 and as a match otherwise.
- R10: The decision outputs keep their values until a new start-marked word is accepted. `dec_valid` is 0 on the cycle after a start-marked word that carries no end marker.
- R11: All configuration inputs are sampled with the start-marked word. Changes that occur later in the packet do not affect that packet's decision.
- R12: Words after the fifth, and valid words outside a packet, do not change the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Trace function enable for this port |
| cfg_drop | input | 1 | Hit action: 0 copy to trace port, 1 drop |
| cfg_trace_port | input | PORT_W (4) | Trace destination port index |
| cfg_cmp_en | input | NCMP (4) | Per-comparator enable |
| cfg_value | input | NCMP*WIN_BITS (640) | Comparator values, comparator c at [160c+159:160c] |
| cfg_mask | input | NCMP*WIN_BITS (640) | Comparator care masks, 1 = compare |
| in_valid | input | 1 | Word valid |
| in_sop | input | 1 | First word of packet |
| in_eop | input | 1 | Last word of packet |
| in_data | input | WORD_W (32) | Packet word |
| dec_valid | output | 1 | Decision valid for current packet |
| dec_code | output | 2 | 0 forward, 1 forward and copy, 2 drop |
| dec_trace_port | output | PORT_W (4) | Trace destination of the decided packet |

## Verification
Two events can land in the same cycle. The first case is a one-word packet, where the start marker clears the previous decision and the end marker must produce the new one. The second case is back-to-back packets, where a new start follows directly after the word that completed the previous decision. The bench drives both shapes, and changes configuration inside a packet. A behavioural model runs alongside the design and is compared with it every clock. The model keeps the received window, the sampled settings and a word count. The outputs must show the new decision on the following cycle, with the settings captured at that packet's start and not the settings applied later.

// File: rtl/trace_snoop_pkg.sv
package trace_snoop_pkg;
  typedef enum logic [1:0] {
    ACT_FWD  = 2'd0,
    ACT_COPY = 2'd1,
    ACT_DROP = 2'd2
  } trace_act_e;
endpackage

// File: rtl/trace_cfg_hold.sv
module trace_cfg_hold #(
  parameter int WIN_BITS = 160,
  parameter int NCMP     = 4,
  parameter int PORT_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic                     live_en,
  input  logic                     live_drop,
  input  logic [PORT_W-1:0]        live_port,
  input  logic [NCMP-1:0]          live_cmp_en,
  input  logic [NCMP*WIN_BITS-1:0] live_value,
  input  logic [NCMP*WIN_BITS-1:0] live_mask,
  output logic                     eff_en,
  output logic                     eff_drop,
  output logic [PORT_W-1:0]        eff_port,
  output logic [NCMP-1:0]          eff_cmp_en,
  output logic [NCMP*WIN_BITS-1:0] eff_value,
  output logic [NCMP*WIN_BITS-1:0] eff_mask
);
  logic                     h_en, h_drop;
  logic [PORT_W-1:0]        h_port;
  logic [NCMP-1:0]          h_cmp_en;
  logic [NCMP*WIN_BITS-1:0] h_value, h_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      h_en     <= 1'b0;
      h_drop   <= 1'b0;
      h_port   <= '0;
      h_cmp_en <= '0;
      h_value  <= '0;
      h_mask   <= '0;
    end else if (load) begin
      h_en     <= live_en;
      h_drop   <= live_drop;
      h_port   <= live_port;
      h_cmp_en <= live_cmp_en;
      h_value  <= live_value;
      h_mask   <= live_mask;
    end
  end

  // The start word itself sees the live settings; later words see the copy.
  assign eff_en     = load ? live_en     : h_en;
  assign eff_drop   = load ? live_drop   : h_drop;
  assign eff_port   = load ? live_port   : h_port;
  assign eff_cmp_en = load ? live_cmp_en : h_cmp_en;
  assign eff_value  = load ? live_value  : h_value;
  assign eff_mask   = load ? live_mask   : h_mask;
endmodule

// File: rtl/trace_cmp_lane.sv
module trace_cmp_lane #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 5,
  parameter int CNT_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     step,
  input  logic [CNT_W-1:0]         idx,
  input  logic [WORD_W-1:0]        data,
  input  logic [NWORDS*WORD_W-1:0] value,
  input  logic [NWORDS*WORD_W-1:0] mask,
  output logic                     match_now,
  output logic                     tail_clear
);
  logic             acc;
  logic [CNT_W-1:0] sel;
  logic [WORD_W-1:0] w_val, w_mask;
  logic             word_ok;

  assign sel     = (idx < CNT_W'(NWORDS)) ? idx : '0;
  assign w_val   = value[sel*WORD_W +: WORD_W];
  assign w_mask  = mask[sel*WORD_W +: WORD_W];
  assign word_ok = ((data ^ w_val) & w_mask) == '0;

  assign match_now = (start ? 1'b1 : acc) & word_ok;

  // Window words after the current one must be fully masked if the packet ends here.
  always_comb begin
    tail_clear = 1'b1;
    for (int k = 0; k < NWORDS; k++) begin
      if (k > int'(idx) && (|mask[k*WORD_W +: WORD_W]))
        tail_clear = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       acc <= 1'b0;
    else if (step) acc <= match_now;
  end
endmodule

// File: rtl/trace_snoop_filter.sv
module trace_snoop_filter
  import trace_snoop_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int WIN_BITS = 160,
  parameter int NCMP     = 4,
  parameter int NPORTS   = 16,
  localparam int PORT_W  = $clog2(NPORTS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_en,
  input  logic                     cfg_drop,
  input  logic [PORT_W-1:0]        cfg_trace_port,
  input  logic [NCMP-1:0]          cfg_cmp_en,
  input  logic [NCMP*WIN_BITS-1:0] cfg_value,
  input  logic [NCMP*WIN_BITS-1:0] cfg_mask,
  input  logic                     in_valid,
  input  logic                     in_sop,
  input  logic                     in_eop,
  input  logic [WORD_W-1:0]        in_data,
  output logic                     dec_valid,
  output logic [1:0]               dec_code,
  output logic [PORT_W-1:0]        dec_trace_port
);
  localparam int NWORDS = WIN_BITS / WORD_W;
  localparam int CNT_W  = $clog2(NWORDS + 1);

  logic                     start, step, last, busy, done, any_hit;
  logic [CNT_W-1:0]         idx, cur_idx;
  logic                     e_en, e_drop;
  logic [PORT_W-1:0]        e_port;
  logic [NCMP-1:0]          e_cmp_en, hit;
  logic [NCMP*WIN_BITS-1:0] e_value, e_mask;
  trace_act_e               act;

  assign start   = in_valid && in_sop;
  assign step    = in_valid && (in_sop || (busy && !done));
  assign cur_idx = in_sop ? '0 : idx;
  assign last    = step && (cur_idx == CNT_W'(NWORDS - 1) || in_eop);

  trace_cfg_hold #(.WIN_BITS(WIN_BITS), .NCMP(NCMP), .PORT_W(PORT_W)) u_hold (
    .clk(clk), .rst(rst), .load(start),
    .live_en(cfg_en), .live_drop(cfg_drop), .live_port(cfg_trace_port),
    .live_cmp_en(cfg_cmp_en), .live_value(cfg_value), .live_mask(cfg_mask),
    .eff_en(e_en), .eff_drop(e_drop), .eff_port(e_port),
    .eff_cmp_en(e_cmp_en), .eff_value(e_value), .eff_mask(e_mask)
  );

  for (genvar c = 0; c < NCMP; c++) begin : g_lane
    logic m_now, t_clr;
    trace_cmp_lane #(.WORD_W(WORD_W), .NWORDS(NWORDS), .CNT_W(CNT_W)) u_lane (
      .clk(clk), .rst(rst), .start(start), .step(step), .idx(cur_idx),
      .data(in_data),
      .value(e_value[c*WIN_BITS +: NWORDS*WORD_W]),
      .mask(e_mask[c*WIN_BITS +: NWORDS*WORD_W]),
      .match_now(m_now), .tail_clear(t_clr)
    );
    assign hit[c] = m_now && t_clr && e_cmp_en[c];
  end

  assign any_hit = e_en && (|hit);

  always_comb begin
    if (!any_hit)    act = ACT_FWD;
    else if (e_drop) act = ACT_DROP;
    else             act = ACT_COPY;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy           <= 1'b0;
      done           <= 1'b0;
      idx            <= '0;
      dec_valid      <= 1'b0;
      dec_code       <= ACT_FWD;
      dec_trace_port <= '0;
    end else begin
      if (start) begin
        dec_valid <= 1'b0;
        busy      <= !in_eop;
        done      <= 1'b0;
        idx       <= CNT_W'(1);
      end else if (in_valid && busy) begin
        if (!done) idx <= idx + 1'b1;
        if (in_eop) busy <= 1'b0;
      end
      if (last) begin
        dec_valid      <= 1'b1;
        dec_code       <= act;
        dec_trace_port <= e_port;
        done           <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/trace_snoop_chk.sv
module trace_snoop_chk #(
  parameter int PORT_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_en,
  input logic              in_valid,
  input logic              in_sop,
  input logic              in_eop,
  input logic              dec_valid,
  input logic [1:0]        dec_code,
  input logic [PORT_W-1:0] dec_trace_port
);
  p_sop_clears_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sop && !in_eop) |=> !dec_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !(in_valid && in_sop)) |=>
      (dec_valid && $stable(dec_code) && $stable(dec_trace_port)));

  p_one_word_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sop && in_eop) |=> dec_valid);

  p_legal_code_r4: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (dec_code != 2'd3));

  p_off_forwards_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sop && in_eop && !cfg_en) |=> (dec_code == 2'd0));

  p_rise_needs_word_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(dec_valid) |-> $past(in_valid));
endmodule

bind trace_snoop_filter trace_snoop_chk #(.PORT_W(PORT_W)) u_chk (.*);

// File: tb/tb_trace_snoop_filter.sv
module tb_trace_snoop_filter;
  localparam int CLK_P = 10;
  localparam int W = 32;
  localparam int WIN = 160;
  localparam int NC = 4;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_en = 1'b0, cfg_drop = 1'b0;
  logic [PW-1:0] cfg_trace_port = '0;
  logic [NC-1:0] cfg_cmp_en = '0;
  logic [NC*WIN-1:0] cfg_value = '0, cfg_mask = '0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [W-1:0] in_data = '0;
  logic dec_valid;
  logic [1:0] dec_code;
  logic [PW-1:0] dec_trace_port;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  string cur_req = "R1";

  trace_snoop_filter dut (.*);

  always #(CLK_P/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  bit m_busy, m_done, m_en, m_drop;
  int m_cnt;
  logic [PW-1:0] m_port;
  logic [NC-1:0] m_cmp_en;
  logic [NC*WIN-1:0] m_val, m_mask;
  logic [WIN-1:0] m_win;
  bit exp_valid;
  int exp_code;
  logic [PW-1:0] exp_port;

  task automatic model_decide();
    bit hit = 0;
    for (int c = 0; c < NC; c++) begin
      bit ok = 1;
      if (!m_cmp_en[c]) continue;
      for (int b = 0; b < WIN; b++) begin
        if (m_mask[c*WIN+b]) begin
          if (b >= m_cnt*W) ok = 0;
          else if (m_win[b] !== m_val[c*WIN+b]) ok = 0;
        end
      end
      if (ok) hit = 1;
    end
    if (!m_en) hit = 0;
    exp_code  = hit ? (m_drop ? 2 : 1) : 0;
    exp_port  = m_port;
    exp_valid = 1;
    m_done    = 1;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_cnt = 0;
      exp_valid = 0; exp_code = 0; exp_port = '0;
    end else begin
      if (in_valid && in_sop) begin
        m_en = cfg_en; m_drop = cfg_drop; m_port = cfg_trace_port;
        m_cmp_en = cfg_cmp_en; m_val = cfg_value; m_mask = cfg_mask;
        m_cnt = 0; m_win = '0; m_busy = 1; m_done = 0; exp_valid = 0;
      end
      if (in_valid && m_busy && !m_done) begin
        m_win[m_cnt*W +: W] = in_data;
        m_cnt++;
        if (m_cnt == 5 || in_eop) model_decide();
      end
      if (in_valid && in_eop) m_busy = 0;
    end
  end

  // per-clock comparison, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_P/4);
    if (!rst && !finished) begin
      n_cmp++;
      if (dec_valid !== exp_valid) begin
        n_bad++;
        $display("FAIL %s dec_valid actual=%0d expected=%0d", cur_req, dec_valid, exp_valid);
      end else if (exp_valid && (dec_code !== 2'(exp_code) || dec_trace_port !== exp_port)) begin
        n_bad++;
        $display("FAIL %s code/port actual=%0d/%0d expected=%0d/%0d",
                 cur_req, dec_code, dec_trace_port, exp_code, exp_port);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  logic [W-1:0] pat [5] = '{32'hDEAD_0001, 32'h1111_2222, 32'h3333_4444,
                            32'h5555_6666, 32'hCAFE_F00D};

  task automatic check(input string req, input int act, input int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic word(input bit s, input bit e, input logic [W-1:0] d);
    @(negedge clk);
    in_valid = 1; in_sop = s; in_eop = e; in_data = d;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0; in_data = '0;
  endtask

  task automatic send(input logic [W-1:0] q[$]);
    foreach (q[i]) word(i == 0, i == q.size() - 1, q[i]);
    idle();
  endtask

  task automatic set_cmp(input int c, input logic [WIN-1:0] v, input logic [WIN-1:0] m);
    cfg_value[c*WIN +: WIN] = v;
    cfg_mask[c*WIN +: WIN]  = m;
  endtask

  function automatic logic [WIN-1:0] pat_vec();
    logic [WIN-1:0] v;
    for (int k = 0; k < 5; k++) v[k*W +: W] = pat[k];
    return v;
  endfunction

  initial begin
    #(CLK_P*100000);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] q[$];
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cur_req = "R10";
    check("R10 reset dec_valid", dec_valid, 0);
    check("R10 reset dec_code", dec_code, 0);

    set_cmp(0, pat_vec(), '1);
    set_cmp(1, 160'h1234_0000, 160'hFFFF_0000);
    cfg_en = 1; cfg_drop = 0; cfg_trace_port = 4'd9; cfg_cmp_en = 4'b0001;

    cur_req = "R1"; // R2 R7 exact match copies to port 9
    q = '{pat[0], pat[1], pat[2], pat[3], pat[4]}; send(q);
    check("R1 exact window copy", dec_code, 1);
    check("R7 trace port", dec_trace_port, 9);

    cur_req = "R5";
    q = '{pat[0], pat[1], pat[2], 32'h0, pat[4]}; send(q);
    check("R5 mismatch forwards", dec_code, 0);

    cur_req = "R12";
    q = '{pat[0], pat[1], pat[2], pat[3], pat[4], 32'h0, 32'h1, 32'h2}; send(q);
    check("R12 trailing words ignored", dec_code, 1);
    word(0, 1, 32'h0); idle(); // stray word outside a packet
    check("R12 stray word keeps decision", dec_code, 1);

    cur_req = "R2";
    cfg_cmp_en = 4'b0011;
    q = '{32'h1234_ABCD, 32'h9, 32'h8, 32'h7, 32'h6}; send(q);
    check("R2 masked bits match", dec_code, 1);

    cur_req = "R3";
    cfg_cmp_en = 4'b0001;
    q = '{32'h1234_ABCD, 32'h9, 32'h8, 32'h7, 32'h6}; send(q);
    check("R3 disabled comparator no hit", dec_code, 0);

    cur_req = "R4";
    cfg_drop = 1;
    q = '{pat[0], pat[1], pat[2], pat[3], pat[4]}; send(q);
    check("R4 drop action", dec_code, 2);

    cur_req = "R6";
    cfg_en = 0;
    q = '{pat[0], pat[1], pat[2], pat[3], pat[4]}; send(q);
    check("R6 port disabled forwards", dec_code, 0);
    cfg_en = 1; cfg_drop = 0;

    cur_req = "R9";
    cfg_cmp_en = 4'b0010;
    q = '{32'h1234_5555, 32'h1}; send(q);
    check("R9 short packet masked tail hits", dec_code, 1);
    cfg_cmp_en = 4'b0001;
    q = '{pat[0], pat[1], pat[2]}; send(q);
    check("R9 short packet unmasked tail misses", dec_code, 0);

    cur_req = "R8";
    cfg_cmp_en = 4'b0010;
    q = '{32'h1234_0000}; send(q);
    check("R8 one-word packet decided", dec_valid, 1);
    check("R8 one-word packet hit", dec_code, 1);
    cfg_cmp_en = 4'b0001;
    word(1, 0, pat[0]);
    word(0, 0, pat[1]);
    check("R10 start clears decision", dec_valid, 0);
    word(0, 0, pat[2]);
    word(0, 0, pat[3]);
    word(0, 0, pat[4]);
    check("R8 not valid after four words", dec_valid, 0);
    word(0, 1, 32'hFFFF_FFFF);
    check("R8 valid after fifth word", dec_valid, 1);
    idle();

    cur_req = "R11";
    word(1, 0, pat[0]);
    word(0, 0, pat[1]);
    cfg_drop = 1; cfg_trace_port = 4'd3;
    word(0, 0, pat[2]);
    word(0, 0, pat[3]);
    word(0, 1, pat[4]);
    idle();
    check("R11 old action kept", dec_code, 1);
    check("R11 old port kept", dec_trace_port, 9);

    cur_req = "R10"; // back-to-back packets, decision then immediate start
    word(1, 0, pat[0]); word(0, 0, pat[1]); word(0, 0, pat[2]);
    word(0, 0, pat[3]); word(0, 1, pat[4]);
    word(1, 1, 32'h0);
    idle();
    check("R10 back-to-back second decision", dec_code, 0);
    repeat (4) idle();
    check("R10 decision held", dec_valid, 1);
    q = '{pat[0], pat[1], pat[2], pat[3], pat[4]}; send(q);
    check("R11 new settings apply", dec_code, 2);
    check("R7 new trace port", dec_trace_port, 3);

    repeat (3) idle();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule